// File: doc/BRIEF.md
# Programmable Color Space Converter

This block converts a video stream, one pixel per clock, between RGB and YCbCr. Each of the three output components is a signed weighted sum of the three input components, using nine coefficients supplied on plain input ports. An offset is taken off each input component before the multiply, and an offset is added to each output component after it. Three offsets (luma, chroma, RGB) are set apart from each other, so one datapath covers both limited-range and full-range forms of the common standard-definition and high-definition matrices.

A two-bit select picks pass-through, RGB-to-YCbCr or YCbCr-to-RGB for each pixel. The select travels down the pipeline together with its pixel. The valid strobe, horizontal sync, vertical sync and data-enable go through a delay of the same length, so they stay aligned with the converted data. A small side function works out the input color format the downstream logic should assume. It chooses between a DVI link, a forced format and the format taken from the received AVI infoframe.

Top module: `colorspace_conv`

## Requirements
- R1: Pixel values presented on `in_c0..in_c2` at clock edge N appear on `out_c0..out_c2` right after edge N+3. The latency is exactly 3 cycles.
- R2: `in_valid`, `in_hs`, `in_vs` and `in_de` appear on `out_valid`, `out_hs`, `out_vs` and `out_de` with the same 3-cycle delay.
- R3: When `xform_sel` = 2'b10 (RGB to YCbCr), the inputs are c0=R, c1=G, c2=B and the outputs are c0=Y, c1=Cb, c2=Cr. `rgb_ofs` is subtracted from every input. `luma_ofs` is added to output c0, and `chroma_ofs` is added to outputs c1 and c2.
- R4: When `xform_sel` = 2'b11 (YCbCr to RGB), the inputs are c0=Y, c1=Cb, c2=Cr. `luma_ofs` is subtracted from c0, and `chroma_ofs` is subtracted from c1 and c2. `rgb_ofs` is added to every output.
- R5: When `xform_sel` is 2'b00 or 2'b01, each output equals its input, whatever the coefficients and offsets are.
- R6: Coefficient k = 3*row + col is used, where row is the output component and col is the input component. It is the 14-bit two's-complement value {`coef_hi`[6k+5:6k], `coef_lo`[8k+7:8k]}, with 2048 standing for 1.0. Output row takes the sum over col of coef(k) * (input col - its input offset).
- R7: The sum is rounded as floor((sum + 1024) / 2048), so an exact half rounds toward plus infinity. This holds for negative sums too.
- R8: After the output offset is added, the result is clamped to the range 0 to 255.
- R9: The mode is sampled with each pixel. Changing `xform_sel` from one pixel to the next affects only the pixels presented while it holds.
- R10: `eff_fmt` gives the input format to assume. It is 2'b00 (RGB 4:4:4) whenever `dvi_link` is 1. Otherwise it is `forced_fmt` when `force_fmt` is 1, and `avi_fmt` when `force_fmt` is 0. The encoding is 00 RGB 4:4:4, 01 YCbCr 4:2:2, 10 YCbCr 4:4:4.
- R11: While `rst_n` is low, every pixel output and every sideband output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| xform_sel | input | 2 | Per-pixel mode: 10 RGB to YCbCr, 11 YCbCr to RGB, other codes pass through |
| coef_lo | input | 72 | Low 8 bits of the nine coefficients, coefficient k at bits 8k+7:8k |
| coef_hi | input | 54 | High 6 bits of the nine coefficients, coefficient k at bits 6k+5:6k |
| luma_ofs | input | 8 | Luma offset |
| chroma_ofs | input | 8 | Chroma offset |
| rgb_ofs | input | 8 | RGB offset |
| dvi_link | input | 1 | Link carries DVI rather than HDMI |
| force_fmt | input | 1 | Use `forced_fmt` instead of the infoframe format |
| forced_fmt | input | 2 | Format chosen by configuration |
| avi_fmt | input | 2 | Format taken from the AVI infoframe |
| eff_fmt | output | 2 | Resolved input color format |
| in_valid | input | 1 | Input pixel strobe |
| in_hs | input | 1 | Input horizontal sync |
| in_vs | input | 1 | Input vertical sync |
| in_de | input | 1 | Input data enable |
| in_c0 | input | 8 | Input component 0 (R or Y) |
| in_c1 | input | 8 | Input component 1 (G or Cb) |
| in_c2 | input | 8 | Input component 2 (B or Cr) |
| out_valid | output | 1 | Delayed pixel strobe |
| out_hs | output | 1 | Delayed horizontal sync |
| out_vs | output | 1 | Delayed vertical sync |
| out_de | output | 1 | Delayed data enable |
| out_c0 | output | 8 | Output component 0 (R or Y) |
| out_c1 | output | 8 | Output component 1 (G or Cb) |
| out_c2 | output | 8 | Output component 2 (B or Cr) |

## Verification
Several behaviours are checked by assertions on every cycle: the sideband delay, the unchanged pass-through, the precedence rules of the format resolver, and the fact that a detected over-range or under-range result saturates the next output. The arithmetic itself cannot be shown this way and is left to the bench scenarios. These cover matrix products in both directions with the standard 601 and 709 coefficient sets in limited and full range, the rounding of exact halves, extreme coefficients that drive the clamp, and the mode changing on every pixel. The bench sweeps a grid of component values that includes 0, 16, 128, 235 and 255 and compares each result against an integer model.

// File: rtl/csc_pkg.sv
package csc_pkg;

  // Per-pixel conversion mode
  typedef enum logic [1:0] {
    XF_PASS_A = 2'b00,
    XF_PASS_B = 2'b01,
    XF_RGB2YC = 2'b10,
    XF_YC2RGB = 2'b11
  } xform_e;

  // Input color format reported to downstream logic
  typedef enum logic [1:0] {
    FMT_RGB   = 2'b00,
    FMT_YC422 = 2'b01,
    FMT_YC444 = 2'b10,
    FMT_RSVD  = 2'b11
  } colfmt_e;

  // Which of the three offsets a component uses
  typedef enum logic [1:0] {
    OFS_NONE,
    OFS_LUMA,
    OFS_CHROMA,
    OFS_RGB
  } ofs_kind_e;

  function automatic logic is_convert(xform_e m);
    return (m == XF_RGB2YC) || (m == XF_YC2RGB);
  endfunction

  // Offset removed from input component ch before the multiply
  function automatic ofs_kind_e in_ofs_kind(xform_e m, int ch);
    case (m)
      XF_RGB2YC: return OFS_RGB;
      XF_YC2RGB: return (ch == 0) ? OFS_LUMA : OFS_CHROMA;
      default:   return OFS_NONE;
    endcase
  endfunction

  // Offset added to output component ch after the multiply
  function automatic ofs_kind_e out_ofs_kind(xform_e m, int ch);
    case (m)
      XF_RGB2YC: return (ch == 0) ? OFS_LUMA : OFS_CHROMA;
      XF_YC2RGB: return OFS_RGB;
      default:   return OFS_NONE;
    endcase
  endfunction

endpackage

// File: rtl/csc_fmt_resolve.sv
module csc_fmt_resolve
  import csc_pkg::*;
(
  input  logic       dvi_link,
  input  logic       force_fmt,
  input  logic [1:0] forced_fmt,
  input  logic [1:0] avi_fmt,
  output logic [1:0] eff_fmt
);

  // A DVI link carries RGB only; otherwise configuration beats the infoframe
  always_comb begin
    if (dvi_link)       eff_fmt = FMT_RGB;
    else if (force_fmt) eff_fmt = forced_fmt;
    else                eff_fmt = avi_fmt;
  end

endmodule

// File: rtl/csc_pipe_delay.sv
module csc_pipe_delay #(
  parameter int W     = 8,
  parameter int DEPTH = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);

  generate
    if (DEPTH == 0) begin : g_wire
      assign dout = din;
    end else begin : g_regs
      logic [W-1:0] stage_q [DEPTH];
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          for (int i = 0; i < DEPTH; i++) stage_q[i] <= '0;
        end else begin
          stage_q[0] <= din;
          for (int i = 1; i < DEPTH; i++) stage_q[i] <= stage_q[i-1];
        end
      end
      assign dout = stage_q[DEPTH-1];
    end
  endgenerate

endmodule

// File: rtl/csc_lane.sv
module csc_lane #(
  parameter int PIX_W  = 8,
  parameter int COEF_W = 14,
  parameter int FRAC   = 11
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic signed [PIX_W+1:0]  d0,
  input  logic signed [PIX_W+1:0]  d1,
  input  logic signed [PIX_W+1:0]  d2,
  input  logic signed [COEF_W-1:0] k0,
  input  logic signed [COEF_W-1:0] k1,
  input  logic signed [COEF_W-1:0] k2,
  input  logic [PIX_W-1:0]         ofs_add,
  output logic [PIX_W-1:0]         y
);

  localparam int DW    = PIX_W + 2;
  localparam int SUM_W = DW + COEF_W + 2;
  localparam int QW    = SUM_W - FRAC + 2;
  localparam logic signed [SUM_W-1:0] HALF = SUM_W'(1) << (FRAC - 1);
  localparam logic signed [QW-1:0]    MAXV = QW'((1 << PIX_W) - 1);

  // Three-term signed dot product at full precision
  function automatic logic signed [SUM_W-1:0] mac3(
    logic signed [DW-1:0] a0, logic signed [DW-1:0] a1, logic signed [DW-1:0] a2,
    logic signed [COEF_W-1:0] b0, logic signed [COEF_W-1:0] b1, logic signed [COEF_W-1:0] b2);
    return SUM_W'(a0) * SUM_W'(b0) + SUM_W'(a1) * SUM_W'(b1) + SUM_W'(a2) * SUM_W'(b2);
  endfunction

  logic signed [SUM_W-1:0] sum_q;
  logic signed [SUM_W-1:0] rnd;
  logic signed [SUM_W-1:0] shf;
  logic signed [QW-1:0]    lvl;
  logic                    sat_hi;
  logic                    sat_lo;

  // Half-LSB rounding, arithmetic shift (floor), then output offset
  assign rnd    = sum_q + HALF;
  assign shf    = rnd >>> FRAC;
  assign lvl    = QW'(shf) + QW'($signed({1'b0, ofs_add}));
  assign sat_hi = lvl > MAXV;
  assign sat_lo = lvl < 0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sum_q <= '0;
      y     <= '0;
    end else begin
      sum_q <= mac3(d0, d1, d2, k0, k1, k2);
      y     <= sat_hi ? '1 : (sat_lo ? '0 : lvl[PIX_W-1:0]);
    end
  end

  // R8
  clamp_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sat_hi |=> (y == '1));

  // R8
  clamp_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sat_lo |=> (y == '0));

endmodule

// File: rtl/colorspace_conv.sv
module colorspace_conv
  import csc_pkg::*;
#(
  parameter int PIX_W     = 8,
  parameter int COEF_W    = 14,
  parameter int COEF_LO_W = 8,
  parameter int FRAC      = 11
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic [1:0]                          xform_sel,
  input  logic [9*COEF_LO_W-1:0]              coef_lo,
  input  logic [9*(COEF_W-COEF_LO_W)-1:0]     coef_hi,
  input  logic [PIX_W-1:0]                    luma_ofs,
  input  logic [PIX_W-1:0]                    chroma_ofs,
  input  logic [PIX_W-1:0]                    rgb_ofs,
  input  logic                                dvi_link,
  input  logic                                force_fmt,
  input  logic [1:0]                          forced_fmt,
  input  logic [1:0]                          avi_fmt,
  output logic [1:0]                          eff_fmt,
  input  logic                                in_valid,
  input  logic                                in_hs,
  input  logic                                in_vs,
  input  logic                                in_de,
  input  logic [PIX_W-1:0]                    in_c0,
  input  logic [PIX_W-1:0]                    in_c1,
  input  logic [PIX_W-1:0]                    in_c2,
  output logic                                out_valid,
  output logic                                out_hs,
  output logic                                out_vs,
  output logic                                out_de,
  output logic [PIX_W-1:0]                    out_c0,
  output logic [PIX_W-1:0]                    out_c1,
  output logic [PIX_W-1:0]                    out_c2
);

  localparam int NCH    = 3;
  localparam int NCOEF  = NCH * NCH;
  localparam int HI_W   = COEF_W - COEF_LO_W;
  localparam int DW     = PIX_W + 2;
  localparam int LAT    = 3;
  localparam int SBW    = 4;
  localparam int RAWW   = NCH * PIX_W;
  localparam int WW     = $clog2(LAT + 1);

  function automatic logic [PIX_W-1:0] pick_ofs(ofs_kind_e k, logic [PIX_W-1:0] l,
                                                logic [PIX_W-1:0] c, logic [PIX_W-1:0] r);
    case (k)
      OFS_LUMA:   return l;
      OFS_CHROMA: return c;
      OFS_RGB:    return r;
      default:    return '0;
    endcase
  endfunction

  // Format resolution
  csc_fmt_resolve u_fmt (
    .dvi_link   (dvi_link),
    .force_fmt  (force_fmt),
    .forced_fmt (forced_fmt),
    .avi_fmt    (avi_fmt),
    .eff_fmt    (eff_fmt)
  );

  // Coefficient assembly from low byte and high part
  logic signed [COEF_W-1:0] coef [NCOEF];
  for (genvar k = 0; k < NCOEF; k++) begin : g_coef
    assign coef[k] = $signed({coef_hi[k*HI_W +: HI_W], coef_lo[k*COEF_LO_W +: COEF_LO_W]});
  end

  logic [PIX_W-1:0] pix_in [NCH];
  assign pix_in[0] = in_c0;
  assign pix_in[1] = in_c1;
  assign pix_in[2] = in_c2;

  xform_e mode_in;
  assign mode_in = xform_e'(xform_sel);

  // Stage 1: input offsets; the mode is captured with the pixel
  xform_e                s1_mode;
  xform_e                s2_mode;
  logic                  s3_conv;
  logic signed [DW-1:0]  s1_d [NCH];
  logic [PIX_W-1:0]      ofs_sub [NCH];
  logic [PIX_W-1:0]      ofs_add [NCH];

  always_comb begin
    for (int j = 0; j < NCH; j++) begin
      ofs_sub[j] = pick_ofs(in_ofs_kind(mode_in, j), luma_ofs, chroma_ofs, rgb_ofs);
      ofs_add[j] = pick_ofs(out_ofs_kind(s2_mode, j), luma_ofs, chroma_ofs, rgb_ofs);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_mode <= XF_PASS_A;
      s2_mode <= XF_PASS_A;
      s3_conv <= 1'b0;
      for (int j = 0; j < NCH; j++) s1_d[j] <= '0;
    end else begin
      s1_mode <= mode_in;
      s2_mode <= s1_mode;
      s3_conv <= is_convert(s2_mode);
      for (int j = 0; j < NCH; j++)
        s1_d[j] <= $signed({2'b00, pix_in[j]}) - $signed({2'b00, ofs_sub[j]});
    end
  end

  // Stages 2 and 3: one multiply-accumulate lane per output component
  logic [PIX_W-1:0] lane_y [NCH];
  for (genvar i = 0; i < NCH; i++) begin : g_lane
    csc_lane #(.PIX_W(PIX_W), .COEF_W(COEF_W), .FRAC(FRAC)) u_lane (
      .clk     (clk),
      .rst_n   (rst_n),
      .d0      (s1_d[0]),
      .d1      (s1_d[1]),
      .d2      (s1_d[2]),
      .k0      (coef[i*NCH + 0]),
      .k1      (coef[i*NCH + 1]),
      .k2      (coef[i*NCH + 2]),
      .ofs_add (ofs_add[i]),
      .y       (lane_y[i])
    );
  end

  // Sidebands and raw pixel follow the same number of stages
  logic [SBW+RAWW-1:0] dly_out;
  csc_pipe_delay #(.W(SBW + RAWW), .DEPTH(LAT)) u_dly (
    .clk   (clk),
    .rst_n (rst_n),
    .din   ({in_valid, in_hs, in_vs, in_de, in_c2, in_c1, in_c0}),
    .dout  (dly_out)
  );

  logic [PIX_W-1:0] raw_pix [NCH];
  for (genvar i = 0; i < NCH; i++) begin : g_raw
    assign raw_pix[i] = dly_out[i*PIX_W +: PIX_W];
  end

  assign {out_valid, out_hs, out_vs, out_de} = dly_out[RAWW +: SBW];
  assign out_c0 = s3_conv ? lane_y[0] : raw_pix[0];
  assign out_c1 = s3_conv ? lane_y[1] : raw_pix[1];
  assign out_c2 = s3_conv ? lane_y[2] : raw_pix[2];

  // Cycles since reset, saturating, so history checks look no further back
  logic [WW-1:0] warm_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    warm_q <= '0;
    else if (warm_q != WW'(LAT))   warm_q <= warm_q + 1'b1;
  end

  // R2
  sideband_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (warm_q == WW'(LAT)) |->
      ({out_valid, out_hs, out_vs, out_de} == $past({in_valid, in_hs, in_vs, in_de}, 3)));

  // R5
  passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((warm_q == WW'(LAT)) && !$past(xform_sel[1], 3)) |->
      ({out_c2, out_c1, out_c0} == $past({in_c2, in_c1, in_c0}, 3)));

  // R10
  dvi_rgb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dvi_link |-> (eff_fmt == FMT_RGB));

  // R10
  force_fmt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!dvi_link && force_fmt) |-> (eff_fmt == forced_fmt));

endmodule

// File: tb/test_colorspace_conv.sv
module test_colorspace_conv;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  xform_sel = 2'b00;
  logic [71:0] coef_lo = '0;
  logic [53:0] coef_hi = '0;
  logic [7:0]  luma_ofs = 8'h10, chroma_ofs = 8'h80, rgb_ofs = 8'h00;
  logic        dvi_link = 1'b0, force_fmt = 1'b0;
  logic [1:0]  forced_fmt = 2'b00, avi_fmt = 2'b00;
  logic [1:0]  eff_fmt;
  logic        in_valid = 1'b0, in_hs = 1'b0, in_vs = 1'b0, in_de = 1'b0;
  logic [7:0]  in_c0 = '0, in_c1 = '0, in_c2 = '0;
  logic        out_valid, out_hs, out_vs, out_de;
  logic [7:0]  out_c0, out_c1, out_c2;

  always #2 clk = ~clk;

  colorspace_conv i_colorspace_conv (
    .clk(clk), .rst_n(rst_n), .xform_sel(xform_sel), .coef_lo(coef_lo), .coef_hi(coef_hi),
    .luma_ofs(luma_ofs), .chroma_ofs(chroma_ofs), .rgb_ofs(rgb_ofs),
    .dvi_link(dvi_link), .force_fmt(force_fmt), .forced_fmt(forced_fmt), .avi_fmt(avi_fmt),
    .eff_fmt(eff_fmt), .in_valid(in_valid), .in_hs(in_hs), .in_vs(in_vs), .in_de(in_de),
    .in_c0(in_c0), .in_c1(in_c1), .in_c2(in_c2), .out_valid(out_valid), .out_hs(out_hs),
    .out_vs(out_vs), .out_de(out_de), .out_c0(out_c0), .out_c1(out_c1), .out_c2(out_c2)
  );

  int n_total = 0;
  int n_fail  = 0;
  bit done    = 1'b0;
  int cf [9];

  logic [23:0] h_exp [3];
  logic [3:0]  h_sb  [3];
  bit          h_chk [3] = '{1'b0, 1'b0, 1'b0};
  string       h_tag [3];

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_total++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // R6: bench-side packing of signed coefficients into low byte and high part
  task automatic load_cf(input int a0, input int a1, input int a2, input int a3, input int a4,
                         input int a5, input int a6, input int a7, input int a8);
    cf[0] = a0; cf[1] = a1; cf[2] = a2; cf[3] = a3; cf[4] = a4;
    cf[5] = a5; cf[6] = a6; cf[7] = a7; cf[8] = a8;
    for (int k = 0; k < 9; k++) begin
      logic [13:0] w;
      w = 14'(cf[k]);
      coef_lo[8*k +: 8] = w[7:0];
      coef_hi[6*k +: 6] = w[13:8];
    end
  endtask

  // Integer reference: floor division stated directly instead of by shifting
  function automatic logic [23:0] model(input logic [1:0] m, input logic [7:0] a0,
                                        input logic [7:0] a1, input logic [7:0] a2);
    int a [3];
    int io [3];
    int oo [3];
    logic [23:0] r;
    a[0] = a0; a[1] = a1; a[2] = a2;
    if (!m[1]) return {a2, a1, a0};
    for (int j = 0; j < 3; j++) begin
      if (m == 2'b10) begin
        io[j] = rgb_ofs;
        oo[j] = (j == 0) ? luma_ofs : chroma_ofs;
      end else begin
        io[j] = (j == 0) ? luma_ofs : chroma_ofs;
        oo[j] = rgb_ofs;
      end
    end
    for (int i = 0; i < 3; i++) begin
      int s, t, q, v;
      s = 0;
      for (int j = 0; j < 3; j++) s += cf[3*i + j] * (a[j] - io[j]);
      t = s + 1024;
      if (t >= 0) q = t / 2048;
      else        q = -((-t + 2047) / 2048);
      v = q + oo[i];
      if (v > 255) v = 255;
      if (v < 0)   v = 0;
      r[8*i +: 8] = 8'(v);
    end
    return r;
  endfunction

  function automatic logic [7:0] gv(input int k);
    case (k)
      0: return 8'd0;    1: return 8'd1;    2: return 8'd16;   3: return 8'd100;
      4: return 8'd128;  5: return 8'd235;  6: return 8'd254;  default: return 8'd255;
    endcase
  endfunction

  // One pixel per call: check what was driven three negedges ago, then drive
  task automatic step(input logic [1:0] m, input logic [7:0] a0, input logic [7:0] a1,
                      input logic [7:0] a2, input logic [3:0] sb, input bit chk, input string tag);
    @(negedge clk);
    if (h_chk[2]) begin
      check(h_tag[2], {8'h0, out_c2, out_c1, out_c0}, {8'h0, h_exp[2]});
      check("R2 sideband delay", {28'h0, out_valid, out_hs, out_vs, out_de}, {28'h0, h_sb[2]});
    end
    for (int k = 2; k > 0; k--) begin
      h_exp[k] = h_exp[k-1]; h_sb[k] = h_sb[k-1]; h_chk[k] = h_chk[k-1]; h_tag[k] = h_tag[k-1];
    end
    xform_sel = m; in_c0 = a0; in_c1 = a1; in_c2 = a2;
    {in_valid, in_hs, in_vs, in_de} = sb;
    h_exp[0] = model(m, a0, a1, a2); h_sb[0] = sb; h_chk[0] = chk; h_tag[0] = tag;
  endtask

  task automatic drain();
    for (int k = 0; k < 3; k++) step(2'b00, 8'h00, 8'h00, 8'h00, 4'h0, 1'b0, "idle");
  endtask

  // mode_code < 0 selects a different mode on each pixel
  task automatic sweep(input int mode_code, input string tag);
    for (int a = 0; a < 8; a++)
      for (int b = 0; b < 8; b++)
        for (int c = 0; c < 8; c++) begin
          int idx;
          logic [1:0] m;
          idx = a*64 + b*8 + c;
          m = (mode_code < 0) ? 2'(idx % 4) : 2'(mode_code);
          step(m, gv(a), gv(b), gv(c), 4'(idx * 5 + idx / 3), 1'b1, tag);
        end
    drain();
  endtask

  task automatic fmt_case(input logic d, input logic f, input logic [1:0] ff,
                          input logic [1:0] av, input logic [1:0] exp);
    dvi_link = d; force_fmt = f; forced_fmt = ff; avi_fmt = av;
    #1;
    check("R10 format resolve", {30'h0, eff_fmt}, {30'h0, exp});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_total++; n_fail++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", n_total - n_fail, n_total);
      $finish;
    end
  end

  initial begin
    // R11: outputs stay at zero during reset despite busy inputs
    load_cf(612, 1202, 233, -346, -678, 1024, 1024, -858, -166);
    xform_sel = 2'b10; in_c0 = 8'hA5; in_c1 = 8'h5A; in_c2 = 8'hFF;
    {in_valid, in_hs, in_vs, in_de} = 4'hF;
    repeat (5) @(negedge clk);
    check("R11 reset pixels", {8'h0, out_c2, out_c1, out_c0}, 32'h0);
    check("R11 reset sidebands", {28'h0, out_valid, out_hs, out_vs, out_de}, 32'h0);
    rst_n = 1'b1;

    // R10 resolver precedence
    fmt_case(1'b1, 1'b1, 2'b10, 2'b01, 2'b00);
    fmt_case(1'b1, 1'b0, 2'b01, 2'b10, 2'b00);
    fmt_case(1'b0, 1'b1, 2'b01, 2'b10, 2'b01);
    fmt_case(1'b0, 1'b0, 2'b01, 2'b10, 2'b10);
    fmt_case(1'b0, 1'b1, 2'b10, 2'b00, 2'b10);
    dvi_link = 1'b0; force_fmt = 1'b0;

    drain();
    // R5 R1: both pass codes ignore the nonzero coefficients and offsets
    luma_ofs = 8'h10; chroma_ofs = 8'h80; rgb_ofs = 8'h10;
    sweep(0, "R5 R1 pass code 00");
    sweep(1, "R5 R1 pass code 01");

    // R3: 601 RGB to YCbCr, limited then full range
    load_cf(526, 1032, 201, -304, -596, 900, 900, -753, -147);
    luma_ofs = 8'h10; chroma_ofs = 8'h80; rgb_ofs = 8'h00;
    sweep(2, "R3 601 limited");
    load_cf(612, 1202, 233, -346, -678, 1024, 1024, -858, -166);
    luma_ofs = 8'h00;
    sweep(2, "R3 601 full");

    // R4 R6: 709 YCbCr to RGB with negative coefficients
    load_cf(2385, 0, 3671, 2385, -437, -1091, 2385, 4326, 0);
    luma_ofs = 8'h10; chroma_ofs = 8'h80; rgb_ofs = 8'h00;
    sweep(3, "R4 R6 709 limited");
    load_cf(2048, 0, 3225, 2048, -384, -959, 2048, 3800, 0);
    luma_ofs = 8'h00; rgb_ofs = 8'h10;
    sweep(3, "R4 R6 709 full");

    // R7: gain of one half exposes exact halves of both signs
    load_cf(1024, 0, 0, 0, 1024, 0, 0, 0, 1024);
    luma_ofs = 8'h10; chroma_ofs = 8'h80; rgb_ofs = 8'h40;
    sweep(3, "R7 rounding");

    // R8 R6: coefficient extremes drive both clamp limits
    load_cf(8191, 8191, 8191, -8192, -8192, -8192, 8191, -8192, 0);
    luma_ofs = 8'h10; chroma_ofs = 8'h80; rgb_ofs = 8'h10;
    sweep(2, "R8 R6 clamp");

    // R9: mode changes on every pixel
    load_cf(612, 1202, 233, -346, -678, 1024, 1024, -858, -166);
    luma_ofs = 8'h10; chroma_ofs = 8'h80; rgb_ofs = 8'h00;
    sweep(-1, "R9 per-pixel mode");

    done = 1'b1;
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end

endmodule